// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs one complete conversion on an external 12-bit successive-approximation converter across a four-wire serial link. A request carries a 3-bit channel number and a mode select (single-ended or pseudo-differential). When the request is accepted, the sequencer lowers chip select and toggles the serial clock at a rate set by a divide parameter. It first shifts a command out on the data line to the converter. It then lets the sampling window pass with the clock still running, and collects the serial result from the converter's data line.

The captured code is presented on `result` with a one-cycle `done` pulse. After each frame, chip select stays high for a guaranteed minimum time before the next request can start a frame. A request that arrives while a frame or the idle gap is in progress has no effect. Each frame sends a new command, so no configuration is kept from one conversion to the next.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, and whenever no frame is running, `cs_n` is high, `sclk` is low, and `busy` and `done` are low.
- R2: A `req` seen high in idle makes `cs_n` go low on the next clock edge. `busy` is high from that edge until the idle gap has ended.
- R3: The command goes out on `mosi` most significant bit first and is captured by the converter on rising `sclk` edges 1 to 5. Its bits are: a 1 start bit, the mode bit (1 = single-ended, 0 = pseudo-differential), then `chan[2]`, `chan[1]`, `chan[0]`. In pseudo-differential mode, `chan[2:1]` picks the pair and `chan[0]`=1 makes the odd channel the positive input. `mosi` changes only while `sclk` is low.
- R4: Each serial bit period is DIV system clocks: DIV/2 clocks low, then DIV/2 clocks high. Every frame has exactly 18 rising edges. `sclk` is low whenever `cs_n` is high.
- R5: `miso` is sampled on rising `sclk` edges. The bit taken on edge 6 is a null bit and is discarded. The bits taken on edges 7 to 18 form the 12-bit result, most significant bit first.
- R6: `done` is high for exactly one system clock per frame, at the moment `result` holds the new code. `result` keeps that value until the next `done`.
- R7: Between two frames, `cs_n` stays high for at least GAP+1 system clocks.
- R8: A `req` that arrives while `busy` is high starts no frame and changes no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a conversion (used only when idle) |
| single_end | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| chan | input | 3 | Channel number, or pair and polarity |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial command to the converter |
| busy | output | 1 | Frame or idle gap in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | RES_W | Last converted code |

## Verification
The bench builds the block with DIV=4 and GAP=3. With these values a frame is short, so the bench can run many back-to-back conversions across every channel and both modes in a few thousand cycles. The small gap makes the minimum chip-select high time exactly measurable. A model of the converter decodes the received command and returns the stored level for single-ended mode, or a difference clipped at zero for pseudo-differential mode. This covers the codes 000h and FFFh and both polarities of each pair. Stray requests are issued during frames and during the gap.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV   = 8,
  parameter int GAP   = 4,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             single_end,
  input  logic [2:0]       chan,
  input  logic             miso,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int HALF  = DIV / 2;
  localparam int CMD_W = 5;
  localparam int SKIP  = CMD_W + 1;
  localparam int FRAME = SKIP + RES_W;
  localparam int DW    = $clog2(DIV) + 1;
  localparam int BW    = $clog2(FRAME) + 1;
  localparam int GW    = $clog2(GAP + 2) + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  st_t              st;
  logic [DW-1:0]    div_cnt;
  logic [BW-1:0]    bit_idx;
  logic [CMD_W-1:0] cmd_sh;
  logic [GW-1:0]    gap_cnt;
  logic [RES_W-1:0] shreg;

  wire rise = (st == S_XFER) && (div_cnt == DW'(HALF - 1));
  wire last = (st == S_XFER) && (div_cnt == DW'(DIV - 1));
  wire fin  = last && (bit_idx == BW'(FRAME - 1));

  assign busy = (st != S_IDLE);
  assign cs_n = (st != S_XFER);
  assign sclk = (st == S_XFER) && (div_cnt >= DW'(HALF));
  assign mosi = (st == S_XFER) && cmd_sh[CMD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div_cnt <= '0;
      bit_idx <= '0;
      cmd_sh  <= '0;
      gap_cnt <= '0;
      shreg   <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          cmd_sh  <= {1'b1, single_end, chan};
          div_cnt <= '0;
          bit_idx <= '0;
          st      <= S_XFER;
        end
        S_XFER: begin
          div_cnt <= last ? '0 : div_cnt + 1'b1;
          if (rise && bit_idx >= BW'(SKIP))
            shreg <= {shreg[RES_W-2:0], miso};
          if (last) begin
            bit_idx <= bit_idx + 1'b1;
            cmd_sh  <= {cmd_sh[CMD_W-2:0], 1'b0};
          end
          if (fin) begin
            result  <= shreg;
            done    <= 1'b1;
            gap_cnt <= '0;
            st      <= S_GAP;
          end
        end
        S_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GW'(GAP - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [GW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= GW'(GAP + 1);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt < GW'(GAP + 1)) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !done));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));
  a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= GW'(GAP + 1)));
  a_r2_busy_framed: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int DIV = 4;
  localparam int GAP = 3;
  localparam int TCK = 20;

  logic clk = 0, rst_n = 0, req = 0, single_end = 0, miso = 0;
  logic [2:0] chan = 0;
  logic cs_n, sclk, mosi, busy, done;
  logic [11:0] result;

  adc_seq_ctrl #(.DIV(DIV), .GAP(GAP), .RES_W(12)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .single_end(single_end), .chan(chan),
    .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy),
    .done(done), .result(result));

  always #(TCK/2) clk = ~clk;

  int vectors = 0, miscompares = 0, done_cnt = 0, pushed = 0;
  logic [11:0] lvl [8];
  logic [11:0] exp_res_q [$];
  logic [4:0]  exp_cmd_q [$];
  logic [4:0]  got_cmd_q [$];

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [11:0] model(input logic [4:0] c);
    logic [11:0] p, n;
    if (c[3]) return lvl[c[2:0]];
    p = c[0] ? lvl[{c[2:1], 1'b1}] : lvl[{c[2:1], 1'b0}];
    n = c[0] ? lvl[{c[2:1], 1'b0}] : lvl[{c[2:1], 1'b1}];
    return (p > n) ? p - n : 12'h000;
  endfunction

  // converter model
  int rcnt = 0;
  logic [4:0] rcv = 0;
  logic [11:0] code = 0;
  realtime t_rise = 0, t_cs_hi = 0;
  bit first_frame = 1;
  always @(negedge cs_n) begin
    rcnt = 0; rcv = 0;
    if (!first_frame)
      chk(($realtime - t_cs_hi) >= (GAP + 1) * TCK, "R7 cs_n high time",
          int'(($realtime - t_cs_hi) / TCK), GAP + 1);
  end
  always @(posedge sclk) begin
    if (rcnt > 0 && rcnt < 3)
      chk(($realtime - t_rise) == DIV * TCK, "R4 sclk period",
          int'(($realtime - t_rise) / TCK), DIV);
    t_rise = $realtime;
    rcnt++;
    if (rcnt <= 5) rcv = {rcv[3:0], mosi};
    if (rcnt == 5) begin
      code = model(rcv);
      got_cmd_q.push_back(rcv);
    end
  end
  always @(negedge sclk) begin
    if (rcnt == 1)
      chk(($realtime - t_rise) == (DIV / 2) * TCK, "R4 sclk high time",
          int'(($realtime - t_rise) / TCK), DIV / 2);
    if (rcnt == 5) miso = 1'b0;
    else if (rcnt >= 6 && rcnt < 18) miso = code[17 - rcnt];
  end
  always @(posedge cs_n) if (rst_n) begin
    t_cs_hi = $realtime;
    first_frame = 0;
    chk(rcnt == 18, "R4 rising edges per frame", rcnt, 18);
    chk(sclk == 1'b0, "R4 sclk low after frame", sclk, 0);
  end

  // monitor
  logic [11:0] held = 0;
  always @(negedge clk) if (rst_n) begin
    if (done) begin
      logic [11:0] er;
      logic [4:0] ec, gc;
      done_cnt++;
      held = result;
      if (exp_res_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
      else begin
        er = exp_res_q.pop_front();
        ec = exp_cmd_q.pop_front();
        gc = (got_cmd_q.size() != 0) ? got_cmd_q.pop_front() : 5'h00;
        chk(result == er, "R5 result", result, er);
        chk(gc == ec, "R3 command bits", gc, ec);
      end
    end else if (done_cnt > 0) begin
      chk(result == held, "R6 result held", result, held);
    end
  end

  task automatic conv(input logic sgl, input logic [2:0] ch, input bit stray);
    logic [4:0] c;
    @(negedge clk);
    while (busy) @(negedge clk);
    c = {1'b1, sgl, ch};
    exp_cmd_q.push_back(c);
    exp_res_q.push_back(model(c));
    pushed++;
    req = 1; single_end = sgl; chan = ch;
    @(negedge clk);
    req = 0;
    chk(cs_n == 1'b0 && busy, "R2 frame start", {busy, cs_n}, 2'b10);
    if (stray) begin
      repeat (20) @(negedge clk);
      req = 1; single_end = ~sgl; chan = ~ch;
      @(negedge clk);
      req = 0;
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", done, 0);
      req = 1;
      @(negedge clk);
      req = 0;
    end
  endtask

  initial begin
    lvl[0] = 12'hFFF; lvl[1] = 12'h000; lvl[2] = 12'hA5C; lvl[3] = 12'h3C1;
    lvl[4] = 12'h800; lvl[5] = 12'h7FF; lvl[6] = 12'h001; lvl[7] = 12'hFFE;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done, "R1 reset state",
        {cs_n, sclk, busy, done}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !done, "R1 idle after reset",
        {cs_n, sclk, busy, done}, 4'b1000);
    for (int i = 0; i < 8; i++) conv(1'b1, 3'(i), 1'b0);
    for (int i = 0; i < 8; i++) conv(1'b0, 3'(i), 1'b0);
    conv(1'b1, 3'd2, 1'b1);
    conv(1'b0, 3'd5, 1'b1);
    lvl[3] = 12'h555; lvl[2] = 12'h0AA;
    conv(1'b0, 3'd3, 1'b0);
    conv(1'b1, 3'd3, 1'b0);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == pushed, "R8 frame count", done_cnt, pushed);
    chk(cs_n && !sclk && !busy, "R1 idle at end", {cs_n, sclk, busy}, 3'b100);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * TCK);
    vectors++; miscompares++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule